// File: doc/BRIEF.md
# Asynchronous Parallel Memory Bus Master

This block drives an asynchronous parallel memory device, for example a NOR flash, on its pins: a 21-bit address bus, a 32-bit bidirectional data bus, and three active-low strobes for chip select, output enable and write enable. A host hands it single writes, single reads and burst reads through a valid/ready command port. The block orders the strobes, turns the data bus between driving and sampling, and returns each read word with a one-cycle valid pulse.

Chip select is held low for as long as the block is out of reset, including idle time. Outside an operation the bus rests with output enable and write enable high and the data pins released. A burst read keeps output enable low across every word while the address steps up by one per word. Two run-time counts adapt the timing to slow parts: one sets the width of the write-enable pulse, the other sets how long an address is held before its data is sampled. For board testing, each address pin, data pin and strobe has its own output-enable mask bit. Every pad value is registered back to the host, whichever way the pin is turned.

Top module: `pmb_bus_master`

## Requirements
- R1: While reset is held and right after it is released, the address pins drive zero, all data pins are released, chip select is low, output enable and write enable are high, `cmd_ready` is high and `rsp_valid` is low.
- R2: Whenever `cmd_ready` is high, chip select is low, output enable and write enable are high and no data pin is driven. Output enable and write enable are never low together.
- R3: A write (`cmd_op` = 2'b00) accepted on clock edge E0 shows its address after E0 with the data pins still released. The data pins are driven with the write word after E1, and write enable is still high at that point.
- R4: Write enable goes low after E2 and stays low for `we_wait` cycles (a value of 0 counts as 1). Address and data are stable and driven for that whole window, and output enable stays high.
- R5: The data pins stay driven for one cycle after write enable rises. They are then released, and `cmd_ready` returns in that same cycle.
- R6: A read leaves the data pins released and lowers output enable after E1. It puts the start address out after E2 and never drives the data pins while output enable is low.
- R7: A burst read (`cmd_op` = 2'b10) of N words keeps output enable low for all N words. The address moves up by one, modulo 2^21, right after each word except the last is sampled. `rsp_last` is high only with the final word, and output enable rises and `cmd_ready` returns in the cycle that word is presented.
- R8: A single read (`cmd_op` = 2'b01) returns exactly one word, with `rsp_last` high.
- R9: A burst with a word count of zero completes at once: `cmd_ready` stays high, with no strobe activity and no response.
- R10: Each word is sampled once its address has been out for `rd_wait`+1 cycles. It appears on `rsp_data` with a one-cycle `rsp_valid` pulse in the following cycle, and `rsp_valid` is low between words.
- R11: Every pad output enable is its mask bit AND the block's own drive request. The address and strobe pins request drive whenever out of reset; the data pins request it only while writing. Strobe index 0 is chip select, 1 is output enable, 2 is write enable.
- R12: `rb_addr`, `rb_data` and `rb_ctl` show the pad inputs one clock later, whether or not the pin is driven.
- R13: A command is taken only in a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_op` = 2'b11 is accepted and does nothing, and a command held while the block is busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 00 write, 01 single read, 10 burst read, 11 no operation |
| cmd_addr | input | 21 | Write address or first read address |
| cmd_wdata | input | 32 | Write word |
| cmd_count | input | 16 | Burst word count |
| we_wait | input | 4 | Write-enable low width in cycles (0 acts as 1, typically 2) |
| rd_wait | input | 4 | Extra cycles an address is held before sampling |
| rsp_valid | output | 1 | Read word valid, one cycle |
| rsp_data | output | 32 | Read word |
| rsp_last | output | 1 | Final word of the read |
| addr_oe_mask | input | 21 | Per-pin drive permission, address pins |
| data_oe_mask | input | 32 | Per-pin drive permission, data pins |
| ctl_oe_mask | input | 3 | Per-pin drive permission, strobes |
| mem_addr_o | output | 21 | Address pad output value |
| mem_addr_oe | output | 21 | Address pad output enables |
| mem_addr_i | input | 21 | Address pad input value |
| mem_data_o | output | 32 | Data pad output value |
| mem_data_oe | output | 32 | Data pad output enables |
| mem_data_i | input | 32 | Data pad input value |
| mem_cs_n_o | output | 1 | Chip select pad output value |
| mem_oe_n_o | output | 1 | Output enable pad output value |
| mem_we_n_o | output | 1 | Write enable pad output value |
| mem_ctl_oe | output | 3 | Strobe pad output enables |
| mem_ctl_i | input | 3 | Strobe pad input values |
| rb_addr | output | 21 | Registered address pad readback |
| rb_data | output | 32 | Registered data pad readback |
| rb_ctl | output | 3 | Registered strobe pad readback |

## Verification
Every result has a fixed position relative to the acceptance edge E0. The write address appears after E0 and the data after E1. Write enable falls after E2 and rises after E2+`we_wait`, and the data pins are released one edge after that. For reads, output enable falls after E1 and the address appears after E2, so word i is presented after edge E2+(i+1)(`rd_wait`+1). Readback lags the pads by exactly one edge. The bench drives inputs and samples outputs on falling edges and counts rising edges from E0. At each intermediate falling edge it checks that nothing is early (no valid, strobes still in the expected state), and at the computed falling edge it checks that the result is there.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_BURST = 2'b10,
    OP_NOP   = 2'b11
  } pmb_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_W_DATA,
    S_W_ARM,
    S_W_PULSE,
    S_W_HOLD,
    S_R_OE,
    S_R_ADDR,
    S_R_WAIT
  } pmb_state_e;

  // strobe index order on the pad side
  localparam int CTL_CS = 0;
  localparam int CTL_OE = 1;
  localparam int CTL_WE = 2;
  localparam int NCTL   = 3;

  // number of words a read-type command transfers
  function automatic logic [31:0] words_for(input logic [1:0] op, input logic [31:0] count);
    case (pmb_op_e'(op))
      OP_READ:  return 32'd1;
      OP_BURST: return count;
      default:  return 32'd0;
    endcase
  endfunction

  // countdown load giving a write pulse of max(w,1) cycles
  function automatic logic [31:0] pulse_load(input logic [31:0] w);
    return (w == 32'd0) ? 32'd0 : w - 32'd1;
  endfunction

endpackage

// File: rtl/pmb_seq.sv
module pmb_seq
  import pmb_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [WAIT_W-1:0] we_wait,
  input  logic [WAIT_W-1:0] rd_wait,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              ddrv_q,
  output logic              oe_n_q,
  output logic              we_n_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              addr_step,
  output logic              sample_evt
);

  pmb_state_e        state_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [CNT_W-1:0]  remain_q;
  logic [ADDR_W-1:0] base_q;

  logic              cmd_fire;
  logic              cnt_zero;
  logic              last_word;
  logic [CNT_W-1:0]  req_words;
  logic [WAIT_W-1:0] we_load;

  assign cmd_ready  = (state_q == S_IDLE);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign cnt_zero   = (cnt_q == '0);
  assign last_word  = (remain_q == CNT_W'(1));
  assign sample_evt = (state_q == S_R_WAIT) && cnt_zero;
  assign addr_step  = sample_evt && !last_word;
  assign req_words  = CNT_W'(words_for(cmd_op, 32'(cmd_count)));
  assign we_load    = WAIT_W'(pulse_load(32'(we_wait)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      remain_q  <= '0;
      base_q    <= '0;
      addr_q    <= '0;
      dout_q    <= '0;
      ddrv_q    <= 1'b0;
      oe_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_last  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (cmd_fire) begin
            if (pmb_op_e'(cmd_op) == OP_WRITE) begin
              addr_q  <= cmd_addr;
              dout_q  <= cmd_wdata;
              state_q <= S_W_DATA;
            end else if (req_words != '0) begin
              remain_q <= req_words;
              base_q   <= cmd_addr;
              ddrv_q   <= 1'b0;
              state_q  <= S_R_OE;
            end
          end
        end
        S_W_DATA: begin
          ddrv_q  <= 1'b1;
          state_q <= S_W_ARM;
        end
        S_W_ARM: begin
          we_n_q  <= 1'b0;
          cnt_q   <= we_load;
          state_q <= S_W_PULSE;
        end
        S_W_PULSE: begin
          if (cnt_zero) begin
            we_n_q  <= 1'b1;
            state_q <= S_W_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_W_HOLD: begin
          ddrv_q  <= 1'b0;
          state_q <= S_IDLE;
        end
        S_R_OE: begin
          oe_n_q  <= 1'b0;
          state_q <= S_R_ADDR;
        end
        S_R_ADDR: begin
          addr_q  <= base_q;
          cnt_q   <= rd_wait;
          state_q <= S_R_WAIT;
        end
        S_R_WAIT: begin
          if (sample_evt) begin
            rsp_valid <= 1'b1;
            rsp_data  <= data_in;
            rsp_last  <= last_word;
            if (last_word) begin
              oe_n_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              addr_q   <= addr_q + 1'b1;
              remain_q <= remain_q - 1'b1;
              cnt_q    <= rd_wait;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pmb_pads.sv
module pmb_pads
  import pmb_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] dout_q,
  input  logic              ddrv_q,
  input  logic [NCTL-1:0]   ctl_q,
  input  logic [ADDR_W-1:0] addr_oe_mask,
  input  logic [DATA_W-1:0] data_oe_mask,
  input  logic [NCTL-1:0]   ctl_oe_mask,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] mem_addr_oe,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [DATA_W-1:0] mem_data_oe,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [NCTL-1:0]   mem_ctl_o,
  output logic [NCTL-1:0]   mem_ctl_oe,
  input  logic [NCTL-1:0]   mem_ctl_i,
  output logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data,
  output logic [NCTL-1:0]   rb_ctl
);

  // drive request of each pin group: address and strobes always, data while writing
  logic addr_req;
  assign addr_req = rst_n;

  assign mem_addr_o  = addr_q;
  assign mem_addr_oe = addr_oe_mask & {ADDR_W{addr_req}};
  assign mem_data_o  = dout_q;
  assign mem_data_oe = data_oe_mask & {DATA_W{ddrv_q}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_addr <= '0;
      rb_data <= '0;
    end else begin
      rb_addr <= mem_addr_i;
      rb_data <= mem_data_i;
    end
  end

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    assign mem_ctl_o[g]  = ctl_q[g];
    assign mem_ctl_oe[g] = ctl_oe_mask[g] & addr_req;
    always_ff @(posedge clk) begin
      if (!rst_n) rb_ctl[g] <= 1'b1;
      else        rb_ctl[g] <= mem_ctl_i[g];
    end
  end

endmodule

// File: rtl/pmb_bus_master.sv
module pmb_bus_master
  import pmb_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [WAIT_W-1:0] we_wait,
  input  logic [WAIT_W-1:0] rd_wait,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  input  logic [ADDR_W-1:0] addr_oe_mask,
  input  logic [DATA_W-1:0] data_oe_mask,
  input  logic [2:0]        ctl_oe_mask,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] mem_addr_oe,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [DATA_W-1:0] mem_data_oe,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              mem_cs_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [2:0]        mem_ctl_oe,
  input  logic [2:0]        mem_ctl_i,
  output logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data,
  output logic [2:0]        rb_ctl
);

  localparam logic CS_ACTIVE = 1'b0;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q;
  logic              ddrv_q;
  logic              oe_n_q;
  logic              we_n_q;
  logic              addr_step;
  logic              sample_evt;
  logic [NCTL-1:0]   ctl_q;
  logic [NCTL-1:0]   ctl_pad_o;

  pmb_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_count (cmd_count),
    .we_wait   (we_wait),
    .rd_wait   (rd_wait),
    .data_in   (mem_data_i),
    .addr_q    (addr_q),
    .dout_q    (dout_q),
    .ddrv_q    (ddrv_q),
    .oe_n_q    (oe_n_q),
    .we_n_q    (we_n_q),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .addr_step (addr_step),
    .sample_evt(sample_evt)
  );

  always_comb begin
    ctl_q         = '1;
    ctl_q[CTL_CS] = CS_ACTIVE;
    ctl_q[CTL_OE] = oe_n_q;
    ctl_q[CTL_WE] = we_n_q;
  end

  pmb_pads #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_pads (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_q      (addr_q),
    .dout_q      (dout_q),
    .ddrv_q      (ddrv_q),
    .ctl_q       (ctl_q),
    .addr_oe_mask(addr_oe_mask),
    .data_oe_mask(data_oe_mask),
    .ctl_oe_mask (ctl_oe_mask),
    .mem_addr_o  (mem_addr_o),
    .mem_addr_oe (mem_addr_oe),
    .mem_addr_i  (mem_addr_i),
    .mem_data_o  (mem_data_o),
    .mem_data_oe (mem_data_oe),
    .mem_data_i  (mem_data_i),
    .mem_ctl_o   (ctl_pad_o),
    .mem_ctl_oe  (mem_ctl_oe),
    .mem_ctl_i   (mem_ctl_i),
    .rb_addr     (rb_addr),
    .rb_data     (rb_data),
    .rb_ctl      (rb_ctl)
  );

  assign mem_cs_n_o = ctl_pad_o[CTL_CS];
  assign mem_oe_n_o = ctl_pad_o[CTL_OE];
  assign mem_we_n_o = ctl_pad_o[CTL_WE];

endmodule

// File: rtl/pmb_checker.sv
module pmb_checker #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              oe_n,
  input logic              we_n,
  input logic              ddrv,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dout,
  input logic              addr_step,
  input logic              rsp_valid,
  input logic              rsp_last,
  input logic [DATA_W-1:0] data_oe,
  input logic [DATA_W-1:0] data_mask
);

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  assert_idle_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (oe_n && we_n && !ddrv));

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ddrv);

  assert_we_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (ddrv && $stable(addr) && $stable(dout)));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ddrv);

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_step |=> (addr == $past(addr) + ADDR_W'(1)));

  assert_rsp_under_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!oe_n));

  assert_last_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  assert_mask_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe & ~data_mask) == '0);

endmodule

bind pmb_bus_master pmb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_ready(cmd_ready),
  .oe_n     (oe_n_q),
  .we_n     (we_n_q),
  .ddrv     (ddrv_q),
  .addr     (addr_q),
  .dout     (dout_q),
  .addr_step(addr_step),
  .rsp_valid(rsp_valid),
  .rsp_last (rsp_last),
  .data_oe  (mem_data_oe),
  .data_mask(data_oe_mask)
);

// File: tb/tb_pmb_bus_master.sv
`timescale 1ns/1ps
module tb_pmb_bus_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [20:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic [15:0] cmd_count = '0;
  logic [3:0]  we_wait = 4'd2;
  logic [3:0]  rd_wait = 4'd0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_last;
  logic [20:0] addr_oe_mask = '1;
  logic [31:0] data_oe_mask = '1;
  logic [2:0]  ctl_oe_mask = '1;
  logic [20:0] mem_addr_o, mem_addr_oe, mem_addr_i;
  logic [31:0] mem_data_o, mem_data_oe, mem_data_i;
  logic        mem_cs_n_o, mem_oe_n_o, mem_we_n_o;
  logic [2:0]  mem_ctl_oe, mem_ctl_i;
  logic [20:0] rb_addr;
  logic [31:0] rb_data;
  logic [2:0]  rb_ctl;

  int tests = 0;
  int fails = 0;
  int rsp_seen = 0;
  int oe_low_seen = 0;

  always #2 clk = ~clk;

  pmb_bus_master dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_count(cmd_count),
    .we_wait(we_wait), .rd_wait(rd_wait), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .addr_oe_mask(addr_oe_mask), .data_oe_mask(data_oe_mask),
    .ctl_oe_mask(ctl_oe_mask), .mem_addr_o(mem_addr_o), .mem_addr_oe(mem_addr_oe),
    .mem_addr_i(mem_addr_i), .mem_data_o(mem_data_o), .mem_data_oe(mem_data_oe),
    .mem_data_i(mem_data_i), .mem_cs_n_o(mem_cs_n_o), .mem_oe_n_o(mem_oe_n_o),
    .mem_we_n_o(mem_we_n_o), .mem_ctl_oe(mem_ctl_oe), .mem_ctl_i(mem_ctl_i),
    .rb_addr(rb_addr), .rb_data(rb_data), .rb_ctl(rb_ctl)
  );

  // device contents: a fixed function of the word address
  function automatic logic [31:0] dev_word(input logic [20:0] a);
    return {a[10:0], a} ^ 32'hC3A50F96;
  endfunction

  // pad model: released pins float high, device drives data while selected and enabled
  logic [2:0] ctl_o;
  assign ctl_o = {mem_we_n_o, mem_oe_n_o, mem_cs_n_o};
  always_comb begin
    for (int i = 0; i < 21; i++) mem_addr_i[i] = mem_addr_oe[i] ? mem_addr_o[i] : 1'b1;
    for (int i = 0; i < 3; i++)  mem_ctl_i[i]  = mem_ctl_oe[i] ? ctl_o[i] : 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (mem_data_oe[i])                    mem_data_i[i] = mem_data_o[i];
      else if (!mem_ctl_i[0] && !mem_ctl_i[1]) mem_data_i[i] = dev_word(mem_addr_i)[i];
      else                                   mem_data_i[i] = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid) rsp_seen++;
    if (rst_n && !mem_oe_n_o) oe_low_seen++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [20:0] a, input logic [31:0] wd,
                       input logic [15:0] cnt);
    cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_count = cnt; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_write(input logic [20:0] a, input logic [31:0] wd, input logic [3:0] ww);
    int n;
    n = (ww == 0) ? 1 : int'(ww);
    we_wait = ww;
    issue(2'b00, a, wd, 16'd0);
    chk(mem_addr_o == a && mem_data_oe == 0 && !cmd_ready, "R3 address first",
        {mem_addr_o, mem_data_oe}, {a, 32'h0});
    @(negedge clk);
    chk(mem_data_oe == '1 && mem_data_o == wd && mem_we_n_o, "R3 data before strobe",
        {mem_data_oe, mem_data_o}, {32'hFFFFFFFF, wd});
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(!mem_we_n_o && mem_oe_n_o && mem_addr_o == a && mem_data_o == wd && mem_data_oe == '1,
          "R4 write pulse", {31'h0, mem_we_n_o, mem_data_o}, {32'h0, wd});
    end
    @(negedge clk);
    chk(mem_we_n_o && mem_data_oe == '1 && !cmd_ready, "R5 data hold", {mem_we_n_o, mem_data_oe},
        {1'b1, 32'hFFFFFFFF});
    @(negedge clk);
    chk(mem_data_oe == 0 && cmd_ready && mem_oe_n_o && mem_we_n_o && !mem_cs_n_o,
        "R5 R2 release", {mem_data_oe, cmd_ready}, {32'h0, 1'b1});
  endtask

  task automatic do_read(input logic [1:0] op, input logic [20:0] a, input int words,
                         input logic [3:0] rw);
    logic [20:0] ea;
    rd_wait = rw;
    issue(op, a, 32'h0, 16'(words));
    chk(mem_oe_n_o && mem_data_oe == 0, "R6 released before enable", {mem_oe_n_o, mem_data_oe},
        {1'b1, 32'h0});
    @(negedge clk);
    chk(!mem_oe_n_o && mem_data_oe == 0, "R6 enable low", {mem_oe_n_o, mem_data_oe}, 0);
    @(negedge clk);
    chk(mem_addr_o == a && !rsp_valid, "R6 start address", mem_addr_o, a);
    for (int i = 0; i < words; i++) begin
      for (int w = 0; w < int'(rw); w++) begin
        @(negedge clk);
        chk(!rsp_valid && !mem_oe_n_o, "R10 no early word", {rsp_valid, mem_oe_n_o}, 0);
      end
      @(negedge clk);
      ea = a + 21'(i);
      chk(rsp_valid && rsp_data == dev_word(ea), "R10 word data", {rsp_valid, rsp_data},
          {1'b1, dev_word(ea)});
      chk(rsp_last == (i == words - 1), "R7 R8 last flag", rsp_last, (i == words - 1));
      if (i == words - 1) begin
        chk(mem_oe_n_o && cmd_ready, "R7 enable released after last", {mem_oe_n_o, cmd_ready}, 2'b11);
      end else begin
        chk(!mem_oe_n_o && mem_addr_o == a + 21'(i + 1), "R7 address step", mem_addr_o,
            a + 21'(i + 1));
      end
    end
    @(negedge clk);
    chk(!rsp_valid, "R10 single pulse", rsp_valid, 0);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [20:0] addr;
    logic [31:0] wd;
    logic [15:0] cnt;
    logic [3:0]  ww;
    logic [3:0]  rw;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b00, 21'h00123,  32'hDEADBEEF, 16'd0, 4'd2, 4'd0},
    '{2'b00, 21'h1FFFFF, 32'h00000000, 16'd0, 4'd0, 4'd0},
    '{2'b00, 21'h0AAAA,  32'h0000A5A5, 16'd0, 4'd5, 4'd0},
    '{2'b01, 21'h00010,  32'h0,        16'd0, 4'd2, 4'd0},
    '{2'b01, 21'h12345,  32'h0,        16'd0, 4'd2, 4'd3},
    '{2'b10, 21'h00100,  32'h0,        16'd4, 4'd2, 4'd0},
    '{2'b10, 21'h1FFFFE, 32'h0,        16'd3, 4'd2, 4'd1},
    '{2'b10, 21'h00400,  32'h0,        16'd2, 4'd2, 4'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R13 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_addr_o == 0 && mem_data_oe == 0 && !mem_cs_n_o && mem_oe_n_o && mem_we_n_o &&
        cmd_ready && !rsp_valid, "R1 reset state", {mem_addr_o, mem_data_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_addr_o == 0 && mem_data_oe == 0 && !mem_cs_n_o && mem_oe_n_o && mem_we_n_o &&
        cmd_ready, "R1 after release", {mem_cs_n_o, mem_oe_n_o, mem_we_n_o}, 3'b011);

    // table walk
    foreach (VECS[v]) begin
      if (VECS[v].op == 2'b00) do_write(VECS[v].addr, VECS[v].wd, VECS[v].ww);
      else do_read(VECS[v].op, VECS[v].addr,
                   (VECS[v].op == 2'b01) ? 1 : int'(VECS[v].cnt), VECS[v].rw);
    end

    // R9: zero-length burst
    rsp_seen = 0; oe_low_seen = 0;
    issue(2'b10, 21'h00777, 32'h0, 16'd0);
    chk(cmd_ready && mem_oe_n_o && !rsp_valid, "R9 zero count idle", {cmd_ready, mem_oe_n_o}, 2'b11);
    repeat (4) @(negedge clk);
    chk(rsp_seen == 0 && oe_low_seen == 0, "R9 no activity", rsp_seen, 0);

    // R13: no-operation code
    issue(2'b11, 21'h00055, 32'h1234, 16'd5);
    repeat (4) @(negedge clk);
    chk(cmd_ready && rsp_seen == 0 && oe_low_seen == 0 && mem_we_n_o, "R13 no-op ignored",
        rsp_seen, 0);

    // R13: command held while busy is not taken
    we_wait = 4'd3;
    issue(2'b00, 21'h00042, 32'hCAFEF00D, 16'd0);
    cmd_op = 2'b10; cmd_addr = 21'h00999; cmd_count = 16'd5; cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(cmd_ready && rsp_seen == 0 && oe_low_seen == 0, "R13 busy command dropped",
        {rsp_seen, oe_low_seen}, 0);

    // R11 / R12: masks and readback
    addr_oe_mask = 21'h0000FF;
    ctl_oe_mask  = 3'b110;
    @(negedge clk);
    chk(mem_addr_oe == 21'h0000FF && mem_ctl_oe == 3'b110 && mem_data_oe == 0, "R11 mask gating",
        {mem_addr_oe, mem_ctl_oe}, {21'h0000FF, 3'b110});
    @(negedge clk);
    chk(rb_addr == (21'h1FFF00 | (mem_addr_o & 21'h0000FF)), "R12 address readback", rb_addr,
        21'h1FFF00 | (mem_addr_o & 21'h0000FF));
    chk(rb_ctl == 3'b111 && rb_data == 32'hFFFFFFFF, "R12 strobe and data readback",
        {rb_ctl, rb_data}, {3'b111, 32'hFFFFFFFF});
    addr_oe_mask = '1;
    ctl_oe_mask  = '1;
    @(negedge clk);
    @(negedge clk);
    chk(rb_ctl == 3'b110 && rb_addr == mem_addr_o, "R12 driven readback", rb_ctl, 3'b110);

    // R11: partial data mask during a write
    data_oe_mask = 32'h0000FFFF;
    we_wait = 4'd1;
    issue(2'b00, 21'h00003, 32'h89ABCDEF, 16'd0);
    @(negedge clk);
    chk(mem_data_oe == 32'h0000FFFF, "R11 data mask during write", mem_data_oe, 32'h0000FFFF);
    repeat (4) @(negedge clk);
    data_oe_mask = '1;
    chk(cmd_ready, "R5 ready after masked write", cmd_ready, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule